// File: doc/BRIEF.md
# DMA Interrupt Status and Masking

This block keeps the interrupt bookkeeping for a multi-channel DMA controller. For every channel it stores a raw terminal-count flag and a raw error flag. The transfer engine raises these flags with one-cycle pulses. A terminal-count pulse only counts when the channel's control word asks for an interrupt at the end of its count. Software clears the flags through write-one-to-clear words.

The block holds no mask registers. Each channel's terminal-count and error masks are taken live from that channel's configuration word, so a change to the configuration takes effect in the same cycle. The masked flags are combined into one interrupt line.

A small word-addressed bus gives software read access to several views:
- the raw flags;
- the masked flags, per kind and combined;
- the set of channels whose configuration enable bit is on.

The channel count is a parameter, either 2 or 8.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, or when rst_n is low, every raw terminal-count and raw error bit is zero and irq is low.
- R2: A raw terminal-count bit n becomes 1 at the clock edge where tc_done[n] is high and bit 31 of channel n's control word (ch_ctrl[n*32+31]) is 1. A tc_done pulse with that bit at 0 leaves the flag unchanged.
- R3: A raw error bit n becomes 1 at the clock edge where err_done[n] is high.
- R4: A write (bus_sel=1, bus_wr=1) to word 2 clears each raw terminal-count bit whose bus_wdata bit is 1, and leaves the other bits as they were. A write to word 4 does the same for the raw error bits. With bus_sel low, nothing is cleared.
- R5: When a set pulse and a clear write hit the same bit in the same cycle, the bit ends up 1.
- R6: The terminal-count mask of channel n is bit 15 of its configuration word (ch_cfg[n*32+15]), and its error mask is bit 14. Word 1 reads the masked terminal-count bits. Word 3 reads the masked error bits. Word 0 reads the OR of those two.
- R7: Word 5 reads the raw terminal-count bits, and word 6 reads the raw error bits.
- R8: Word 7 reads a vector whose bit n equals bit 0 of channel n's configuration word.
- R9: irq is high exactly when some raw bit is set together with its mask, of either kind.
- R10: bus_rdata is the addressed word while bus_sel=1 and bus_wr=0, and zero otherwise. Words 2, 4 and 8 to 15 read zero.
- R11: bus_rdata bits at and above NCH always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tc_done | input | NCH | Per-channel end-of-count pulse from the transfer engine |
| err_done | input | NCH | Per-channel error pulse from the transfer engine |
| ch_ctrl | input | NCH*DW | Control words of all channels, channel n at bits n*DW upward |
| ch_cfg | input | NCH*DW | Configuration words of all channels, channel n at bits n*DW upward |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | AW | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a set pulse and a clear write landing on the same flag in one clock. The bench drives tc_done together with a word-2 write of all ones in a single cycle, and err_done together with a word-4 write the same way. It then reads the raw words back to confirm that the set won. A second subtle point is irq staying low while raw flags are set but masked. This is reached by leaving an error flag pending and then flipping only the configuration mask bits.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    tc_done,
  input  logic [NCH-1:0]    err_done,
  input  logic [NCH*DW-1:0] ch_ctrl,
  input  logic [NCH*DW-1:0] ch_cfg,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq
);
  localparam int TC_IE_BIT   = 15;
  localparam int ERR_IE_BIT  = 14;
  localparam int EN_BIT      = 0;
  localparam int TC_REQ_BIT  = 31;
  localparam logic [AW-1:0] W_ANY     = AW'(0);
  localparam logic [AW-1:0] W_TC      = AW'(1);
  localparam logic [AW-1:0] W_TC_CLR  = AW'(2);
  localparam logic [AW-1:0] W_ERR     = AW'(3);
  localparam logic [AW-1:0] W_ERR_CLR = AW'(4);
  localparam logic [AW-1:0] W_TC_RAW  = AW'(5);
  localparam logic [AW-1:0] W_ERR_RAW = AW'(6);
  localparam logic [AW-1:0] W_EN      = AW'(7);

  logic [NCH-1:0] tc_raw, err_raw;
  logic [NCH-1:0] tc_msk, err_msk, en_vec, tc_hit;
  logic [NCH-1:0] tc_clr, err_clr, rd_vec;
  logic           wr_go, rd_go;

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    assign tc_msk[n] = ch_cfg[n*DW + TC_IE_BIT];
    assign err_msk[n] = ch_cfg[n*DW + ERR_IE_BIT];
    assign en_vec[n] = ch_cfg[n*DW + EN_BIT];
    assign tc_hit[n] = tc_done[n] & ch_ctrl[n*DW + TC_REQ_BIT];
  end

  assign wr_go   = bus_sel & bus_wr;
  assign rd_go   = bus_sel & ~bus_wr;
  assign tc_clr  = (wr_go && bus_addr == W_TC_CLR)  ? bus_wdata[NCH-1:0] : '0;
  assign err_clr = (wr_go && bus_addr == W_ERR_CLR) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_raw  <= '0;
      err_raw <= '0;
    end else begin
      tc_raw  <= (tc_raw & ~tc_clr) | tc_hit;
      err_raw <= (err_raw & ~err_clr) | err_done;
    end
  end

  always_comb begin
    case (bus_addr)
      W_ANY:     rd_vec = (tc_raw & tc_msk) | (err_raw & err_msk);
      W_TC:      rd_vec = tc_raw & tc_msk;
      W_ERR:     rd_vec = err_raw & err_msk;
      W_TC_RAW:  rd_vec = tc_raw;
      W_ERR_RAW: rd_vec = err_raw;
      W_EN:      rd_vec = en_vec;
      default:   rd_vec = '0;
    endcase
  end

  assign bus_rdata = rd_go ? {{(DW-NCH){1'b0}}, rd_vec} : '0;
  assign irq = |((tc_raw & tc_msk) | (err_raw & err_msk));
endmodule

module dma_irq_status_chk #(
  parameter int NCH = 8,
  parameter int AW  = 4,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] tc_hit,
  input logic [NCH-1:0] err_done,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic           irq,
  input logic [NCH-1:0] tc_raw,
  input logic [NCH-1:0] err_raw
);
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (tc_raw == '0 && err_raw == '0 && !irq));

  a_r2_tc_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|tc_hit) |=> ((tc_raw & $past(tc_hit)) == $past(tc_hit)));

  a_r3_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (|err_done) |=> ((err_raw & $past(err_done)) == $past(err_done)));

  a_r4_tc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(2))
      |=> ((tc_raw & $past(bus_wdata[NCH-1:0] & ~tc_hit)) == '0));

  a_r4_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == AW'(4))
      |=> ((err_raw & $past(bus_wdata[NCH-1:0] & ~err_done)) == '0));

  a_r9_irq_matches_status: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(0)) |-> (irq == (bus_rdata != '0)));

  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |-> (bus_rdata == '0));

  a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (bus_addr == AW'(2) || bus_addr == AW'(4) || bus_addr > AW'(7)))
      |-> (bus_rdata == '0));

  a_r11_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DW-1:NCH] == '0);
endmodule

bind dma_irq_status dma_irq_status_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tc_hit(tc_hit), .err_done(err_done),
  .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
  .tc_raw(tc_raw), .err_raw(err_raw)
);

// File: tb/test_dma_irq_status.sv
`timescale 1ns/1ps
module test_dma_irq_status;
  localparam int NCH = 8;
  localparam int AW  = 4;
  localparam int DW  = 32;
  localparam time TCK = 20ns;

  typedef struct packed {
    logic [1:0]  op;
    logic [3:0]  addr;
    logic [31:0] data;
    logic [7:0]  tcd, c31, erd, tie, eie, en;
  } row_t;

  localparam logic [1:0] P = 2'd0, W = 2'd1, R = 2'd2, I = 2'd3;
  localparam int NROWS = 29;
  localparam row_t TBL [NROWS] = '{
    '{R, 4'd7, 32'h0000_00A5, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R8
    '{P, 4'd0, 32'h0,         8'h03, 8'h01, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R2 ch1 lacks bit 31
    '{R, 4'd5, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R2 R7
    '{R, 4'd1, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R6
    '{I, 4'd0, 32'h1,         8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R9
    '{P, 4'd0, 32'h0,         8'h00, 8'h00, 8'h11, 8'h0F, 8'hF0, 8'hA5}, // R3
    '{R, 4'd6, 32'h0000_0011, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R3 R7
    '{R, 4'd3, 32'h0000_0010, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R6
    '{R, 4'd0, 32'h0000_0011, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R6
    '{W, 4'd2, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R4
    '{R, 4'd5, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R4
    '{R, 4'd0, 32'h0000_0010, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R6
    '{W, 4'd4, 32'hFFFF_FF10, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R4
    '{R, 4'd6, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R4
    '{R, 4'd0, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R6
    '{I, 4'd0, 32'h0,         8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R9 masked raw
    '{R, 4'd2, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R10
    '{R, 4'd4, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R10
    '{R, 4'd9, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R10
    '{R, 4'd15, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'hA5}, // R10
    '{R, 4'd7, 32'h0000_003C, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R8
    '{R, 4'd3, 32'h0000_0001, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R6 live mask
    '{I, 4'd0, 32'h1,         8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R9
    '{P, 4'd0, 32'h0,         8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R2
    '{R, 4'd5, 32'h0000_00FF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R7 R11
    '{W, 4'd2, 32'h0000_000F, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R4
    '{R, 4'd1, 32'h0000_0000, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R6
    '{R, 4'd5, 32'h0000_00F0, 8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}, // R4
    '{I, 4'd0, 32'h1,         8'h00, 8'h00, 8'h00, 8'h0F, 8'h01, 8'h3C}  // R9
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NCH-1:0]    tc_done = '0, err_done = '0;
  logic [7:0]        c31 = '0, tie = '0, eie = '0, en = '0;
  logic [NCH*DW-1:0] ch_ctrl, ch_cfg;
  logic              bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0]     bus_addr = '0;
  logic [DW-1:0]     bus_wdata = '0;
  logic [DW-1:0]     bus_rdata;
  logic              irq;
  int                nchk = 0, nfail = 0;
  bit                done = 1'b0;

  always #(TCK/2) clk = ~clk;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ch_ctrl[i*DW +: DW] = {c31[i], 31'h0000_0004};
      ch_cfg[i*DW +: DW]  = {16'h0000, tie[i], eie[i], 13'h003E, en[i]};
    end
  end

  dma_irq_status #(.NCH(NCH), .AW(AW), .DW(DW)) i_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .tc_done(tc_done), .err_done(err_done),
    .ch_ctrl(ch_ctrl), .ch_cfg(ch_cfg), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] op, input logic [3:0] a);
    if (op == I) return "R9";
    case (a)
      4'd0, 4'd1, 4'd3: return "R6";
      4'd5, 4'd6:       return "R7";
      4'd7:             return "R8";
      default:          return "R10";
    endcase
  endfunction

  task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    @(negedge clk);
    tc_done = '0; err_done = '0;
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(TCK * 100000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd("R1", 4'd5, 32'h0);
    rd("R1", 4'd6, 32'h0);
    #1 chk("R1", {31'h0, irq}, 32'h0);

    for (int k = 0; k < NROWS; k++) begin
      @(negedge clk);
      tie = TBL[k].tie; eie = TBL[k].eie; en = TBL[k].en;
      tc_done = '0; err_done = '0; c31 = TBL[k].c31;
      bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = TBL[k].addr; bus_wdata = TBL[k].data;
      case (TBL[k].op)
        P: begin tc_done = TBL[k].tcd; err_done = TBL[k].erd; end
        W: begin bus_sel = 1'b1; bus_wr = 1'b1; end
        R: begin bus_sel = 1'b1; #1 chk(tag_of(R, TBL[k].addr), bus_rdata, TBL[k].data); end
        default: begin #1 chk("R9", {31'h0, irq}, {31'h0, TBL[k].data[0]}); end
      endcase
    end

    // R5: set pulse and clear write on the same bit in the same cycle
    @(negedge clk);
    tc_done = 8'h01; c31 = 8'h01;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'hFFFF_FFFF;
    rd("R5", 4'd5, 32'h0000_0001);
    @(negedge clk);
    err_done = 8'h02;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd4; bus_wdata = 32'hFFFF_FFFF;
    rd("R5", 4'd6, 32'h0000_0002);

    // R4: write strobe without bus_sel clears nothing
    @(negedge clk);
    tc_done = '0; err_done = '0;
    bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'hFFFF_FFFF;
    rd("R4", 4'd5, 32'h0000_0001);

    // R10: no read data while bus_sel is low
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 4'd5;
    #1 chk("R10", bus_rdata, 32'h0);

    // R1: reset in mid-run clears pending flags
    @(negedge clk);
    eie = 8'hFF;
    #1 chk("R9", {31'h0, irq}, 32'h1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 chk("R1", {31'h0, irq}, 32'h0);
    rst_n = 1'b1;
    rd("R1", 4'd5, 32'h0);
    rd("R1", 4'd6, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule